// File: doc/BRIEF.md
# Dual Non-Retriggerable One-Shot Pulse Generator

This block holds two independent one-shot channels, each driven by a clock. Every channel has a trigger that fires on a falling edge, a trigger that fires on a rising edge, and an active-low clear. It drives a pulse output together with its exact complement. Each trigger input also acts as the gate for the other one. The falling-edge trigger fires only while the rising-edge input is high. The rising-edge trigger fires only while the falling-edge input is low. After a pulse starts it runs for a programmed number of clock cycles, and further trigger activity cannot restart it or make it longer. The clear input ends a pulse at once and holds the output inactive.

Each channel also has an arming flag. The flag is set whenever clear is inactive and the trigger inputs are not both at their active levels. It is reset whenever the channel fires. When clear is released while both triggers sit at their active levels, the channel fires only if the flag was set. Every input passes through a two-flop synchroniser before any edge is detected, so the pins may be driven asynchronously.

Each channel is controlled by a three-state machine. HOLD is the state while clear is asserted, and it is also the state after reset. IDLE means armed for edges. ACTIVE means a pulse is in progress. The transitions are as follows:
- HOLD→ACTIVE happens when clear is released with the arming flag set and both triggers active.
- HOLD→IDLE happens when clear is released in any other situation.
- IDLE→ACTIVE happens on a qualifying trigger edge.
- ACTIVE→IDLE happens when the cycle count runs out.
- IDLE→HOLD and ACTIVE→HOLD happen on a synchronised clear.

Top module: `dual_oneshot`

## Requirements
- R1: The two channels behave independently. Channel n uses bit n of each trigger and clear bus, bits [8n+7:8n] of `width_i`, and bit n of each output bus.
- R2: A high-to-low change on `fall_trig_i[n]` while `rise_trig_i[n]` is high and `clear_n_i[n]` is high fires a pulse on `q_o[n]`.
- R3: A low-to-high change on `rise_trig_i[n]` while `fall_trig_i[n]` is low and clear is high fires a pulse. A high falling-edge input blocks the rising-edge trigger, and a low rising-edge input blocks the falling-edge trigger.
- R4: While clear is low, `q_o` is 0 and `q_n_o` is 1. A clear that arrives during a pulse ends the pulse.
- R5: While a pulse is running, any edge on either trigger leaves the pulse length unchanged.
- R6: Holding a trigger at its active level never fires a second pulse. Only edges fire.
- R7: When clear rises while `fall_trig_i` is low and `rise_trig_i` is high, a pulse fires only if the arming flag is set. The flag is set while clear is high and either `fall_trig_i` is high or `rise_trig_i` is low. Every firing resets the flag.
- R8: A pulse lasts exactly W clock cycles, where W is the channel's width field sampled when the pulse fires. W = 0 gives 1 cycle. A width change during a pulse has no effect on that pulse.
- R9: A trigger edge or a clear at the pins shows at the outputs on the third rising clock edge after the change. This delay is two synchroniser flops plus the output register.
- R10: After reset, `q_o` is 0 and `q_n_o` is 1. `q_n_o` is always the exact complement of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fall_trig_i | input | NUM_CH | Falling-edge trigger, one bit per channel |
| rise_trig_i | input | NUM_CH | Rising-edge trigger, one bit per channel |
| clear_n_i | input | NUM_CH | Active-low overriding clear, one bit per channel |
| width_i | input | NUM_CH*WIDTH_W | Pulse width in cycles, one field per channel |
| q_o | output | NUM_CH | Pulse output |
| q_n_o | output | NUM_CH | Complement of the pulse output |

## Verification
A wrong state-machine state or a wrong count shows at `q_o` within the same pulse. The pulse comes out too short or too long, a trigger that should be blocked fires one, or an edge during a pulse restarts it. A wrong arming flag stays hidden until the next release of clear with both triggers active. At that release a pulse appears or goes missing three cycles after the pin change. The bench therefore compares both outputs on every cycle against a model built from the requirements. It also sets up the armed and unarmed clear releases on purpose.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'b00,
        ST_IDLE   = 2'b01,
        ST_ACTIVE = 2'b10
    } chan_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_s_i,
    input  logic rise_s_i,
    input  logic clr_n_s_i,
    input  logic fire_i,
    output logic edge_hit_o,
    output logic clr_hit_o
);

    logic fall_d, rise_d, clr_d;
    logic armed;
    logic fall_edge, rise_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_d <= 1'b0;
            rise_d <= 1'b0;
            clr_d  <= 1'b0;
        end else begin
            fall_d <= fall_s_i;
            rise_d <= rise_s_i;
            clr_d  <= clr_n_s_i;
        end
    end

    // Each input qualifies the other.
    assign fall_edge = fall_d & ~fall_s_i & rise_s_i;
    assign rise_edge = ~rise_d & rise_s_i & ~fall_s_i;

    assign edge_hit_o = (fall_edge | rise_edge) & clr_n_s_i;
    assign clr_hit_o  = ~clr_d & clr_n_s_i & ~fall_s_i & rise_s_i & armed;

    // Arming flag: set while clear is inactive and the trigger pair is not
    // at its combined active level, dropped by every firing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 armed <= 1'b0;
        else if (fire_i)                            armed <= 1'b0;
        else if (clr_n_s_i & (fall_s_i | ~rise_s_i)) armed <= 1'b1;
    end

    AST_ARM_DROPS_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> !armed); // R7

    AST_CLR_HIT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit_o |-> (clr_n_s_i && !$past(clr_n_s_i))); // R7

endmodule

// File: rtl/oneshot_chan.sv
module oneshot_chan
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_i,
    input  logic               rise_i,
    input  logic               clr_n_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               q_o,
    output logic               q_n_o
);

    logic fall_s, rise_s, clr_n_s;
    logic edge_hit, clr_hit;
    logic fire;
    logic q_r, qn_r;
    logic [WIDTH_W-1:0] cnt;
    logic [WIDTH_W-1:0] len_m1;
    chan_state_e state, state_nx;

    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fall (
        .clk(clk), .rst_n(rst_n), .d_i(fall_i), .q_o(fall_s));
    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rise (
        .clk(clk), .rst_n(rst_n), .d_i(rise_i), .q_o(rise_s));
    oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clr (
        .clk(clk), .rst_n(rst_n), .d_i(clr_n_i), .q_o(clr_n_s));

    oneshot_trig u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_s_i  (fall_s),
        .rise_s_i  (rise_s),
        .clr_n_s_i (clr_n_s),
        .fire_i    (fire),
        .edge_hit_o(edge_hit),
        .clr_hit_o (clr_hit)
    );

    assign len_m1 = (width_i == '0) ? '0 : (width_i - WIDTH_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (clr_hit) begin
                    state_nx = ST_ACTIVE;
                    fire     = 1'b1;
                end else if (clr_n_s) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (!clr_n_s) begin
                    state_nx = ST_HOLD;
                end else if (edge_hit) begin
                    state_nx = ST_ACTIVE;
                    fire     = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!clr_n_s)        state_nx = ST_HOLD;
                else if (cnt == '0)  state_nx = ST_IDLE;
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // Cycle counter, width captured at the firing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (fire)
            cnt <= len_m1;
        else if (state == ST_ACTIVE && state_nx == ST_ACTIVE)
            cnt <= cnt - WIDTH_W'(1);
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r  <= 1'b0;
            qn_r <= 1'b1;
        end else begin
            q_r  <= (state_nx == ST_ACTIVE);
            qn_r <= (state_nx != ST_ACTIVE);
        end
    end

    assign q_o   = q_r;
    assign q_n_o = qn_r;

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        q_r != qn_r); // R10

    AST_CLEAR_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> (!q_r && qn_r)); // R4

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && clr_n_s && cnt != '0)
        |=> (state == ST_ACTIVE && cnt == ($past(cnt) - WIDTH_W'(1)))); // R5

    AST_FIRE_NEEDS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_r) |-> $past(clr_n_s)); // R2

    AST_WIDTH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_r) |-> (cnt == (($past(width_i) == '0) ? '0
                                : ($past(width_i) - WIDTH_W'(1))))); // R8

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned WIDTH_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           fall_trig_i,
    input  logic [NUM_CH-1:0]           rise_trig_i,
    input  logic [NUM_CH-1:0]           clear_n_i,
    input  logic [NUM_CH*WIDTH_W-1:0]   width_i,
    output logic [NUM_CH-1:0]           q_o,
    output logic [NUM_CH-1:0]           q_n_o
);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            oneshot_chan #(.WIDTH_W(WIDTH_W)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .fall_i (fall_trig_i[g]),
                .rise_i (rise_trig_i[g]),
                .clr_n_i(clear_n_i[g]),
                .width_i(width_i[g*WIDTH_W +: WIDTH_W]),
                .q_o    (q_o[g]),
                .q_n_o  (q_n_o[g])
            );
        end
    endgenerate

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0 && q_n_o == '1)); // R10

endmodule

// File: tb/tb_dual_oneshot.sv
`timescale 1ns/1ps
module tb_dual_oneshot;

    localparam int NCH = 2;
    localparam int WW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]    a_in = '1;
    logic [NCH-1:0]    b_in = '1;
    logic [NCH-1:0]    c_in = '1;
    logic [NCH*WW-1:0] w_in = {8'd7, 8'd5};
    logic [NCH-1:0]    q_o, q_n_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    string cur_req = "R2";

    always #2 clk = ~clk;

    dual_oneshot #(.NUM_CH(NCH), .WIDTH_W(WW)) dut (
        .clk(clk), .rst_n(rst_n),
        .fall_trig_i(a_in), .rise_trig_i(b_in), .clear_n_i(c_in),
        .width_i(w_in), .q_o(q_o), .q_n_o(q_n_o));

    task automatic check_val(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements
    logic [NCH-1:0] m_a1, m_a2, m_b1, m_b2, m_c1, m_c2, m_ap, m_bp, m_cp, m_arm, m_hold;
    int m_left [NCH];

    function automatic int eff_width(input logic [WW-1:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic sa, sb, sc, fe, fc;
        if (!rst_n) begin
            m_a1 <= '0; m_a2 <= '0; m_b1 <= '0; m_b2 <= '0; m_c1 <= '0; m_c2 <= '0;
            m_ap <= '0; m_bp <= '0; m_cp <= '0; m_arm <= '0; m_hold <= '1;
            for (int ch = 0; ch < NCH; ch++) m_left[ch] <= 0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                sa = m_a2[ch]; sb = m_b2[ch]; sc = m_c2[ch];
                fe = sc && !m_hold[ch] && (m_left[ch] == 0) &&
                     ((m_ap[ch] && !sa && sb) || (!m_bp[ch] && sb && !sa));
                fc = m_hold[ch] && sc && !m_cp[ch] && !sa && sb && m_arm[ch];
                if (!sc) begin
                    m_left[ch] <= 0;
                    m_hold[ch] <= 1'b1;
                end else if (fe || fc) begin
                    m_left[ch] <= eff_width(w_in[ch*WW +: WW]);
                    m_hold[ch] <= 1'b0;
                end else begin
                    if (m_left[ch] != 0) m_left[ch] <= m_left[ch] - 1;
                    m_hold[ch] <= 1'b0;
                end
                if (fe || fc)            m_arm[ch] <= 1'b0;
                else if (sc && (sa || !sb)) m_arm[ch] <= 1'b1;
            end
            m_ap <= m_a2; m_bp <= m_b2; m_cp <= m_c2;
            m_a2 <= m_a1; m_b2 <= m_b1; m_c2 <= m_c1;
            m_a1 <= a_in; m_b1 <= b_in; m_c1 <= c_in;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                check_val(int'(q_o[ch]), (m_left[ch] != 0) ? 1 : 0, cur_req);
                check_val(int'(q_n_o[ch]), (m_left[ch] != 0) ? 0 : 1, "R10");
            end
        end
    end

    // Pulse length tracker
    int run_len [NCH];
    int last_len [NCH];
    initial for (int ch = 0; ch < NCH; ch++) begin run_len[ch] = 0; last_len[ch] = 0; end
    always @(posedge clk) begin
        #1;
        for (int ch = 0; ch < NCH; ch++) begin
            if (q_o[ch]) run_len[ch]++;
            else begin
                if (run_len[ch] != 0) last_len[ch] = run_len[ch];
                run_len[ch] = 0;
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(input int ch, input int len, input string req);
        int lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!q_o[ch] && lat < 40);
        check_val(lat, 3, "R9");
        while (q_o[ch]) @(negedge clk);
        check_val(last_len[ch], len, req);
    endtask

    task automatic expect_quiet(input int ch, input int n, input string req);
        repeat (n) begin
            @(negedge clk);
            check_val(int'(q_o[ch]), 0, req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_n(4);
        check_val(int'(q_o), 0, "R10");
        check_val(int'(q_n_o), 3, "R10");
        rst_n = 1'b1;
        wait_n(6);

        // R2, R8, R9: falling edge with rise input high
        cur_req = "R2";
        a_in[0] = 1'b0;
        expect_pulse(0, 5, "R2");
        check_val(last_len[1], 0, "R1");

        // R3, R8: rising edge with fall input low, width 0 -> 1 cycle
        cur_req = "R3";
        w_in[7:0] = 8'd0;
        b_in[0] = 1'b0; wait_n(4);
        b_in[0] = 1'b1;
        expect_pulse(0, 1, "R8");

        // R3: blocking
        a_in[0] = 1'b1; wait_n(4);
        b_in[0] = 1'b0; wait_n(4);
        b_in[0] = 1'b1;
        expect_quiet(0, 8, "R3");
        b_in[0] = 1'b0; wait_n(4);
        a_in[0] = 1'b0;
        expect_quiet(0, 8, "R3");
        a_in[0] = 1'b1; wait_n(4);
        b_in[0] = 1'b1;
        expect_quiet(0, 8, "R3");

        // R5, R8: no retrigger, width captured at fire
        cur_req = "R5";
        w_in[7:0] = 8'd20;
        a_in[0] = 1'b0; wait_n(5);
        check_val(int'(q_o[0]), 1, "R5");
        b_in[0] = 1'b0; wait_n(2);
        b_in[0] = 1'b1; wait_n(2);
        a_in[0] = 1'b1; wait_n(2);
        a_in[0] = 1'b0;
        w_in[7:0] = 8'd3;
        while (q_o[0]) @(negedge clk);
        check_val(last_len[0], 20, "R5");

        // R6: held active levels do not refire
        cur_req = "R6";
        expect_quiet(0, 30, "R6");

        // R4: clear ends a pulse
        cur_req = "R4";
        w_in[7:0] = 8'd30;
        a_in[0] = 1'b1; wait_n(4);
        a_in[0] = 1'b0; wait_n(8);
        check_val(int'(q_o[0]), 1, "R2");
        c_in[0] = 1'b0; wait_n(2);
        check_val(int'(q_o[0]), 1, "R9");
        wait_n(1);
        check_val(int'(q_o[0]), 0, "R4");
        check_val(int'(q_n_o[0]), 1, "R4");
        expect_quiet(0, 10, "R4");

        // R7: release of clear without arming
        cur_req = "R7";
        c_in[0] = 1'b1;
        expect_quiet(0, 12, "R7");

        // R7: armed release of clear fires
        w_in[7:0] = 8'd4;
        a_in[0] = 1'b1; wait_n(4);
        c_in[0] = 1'b0; wait_n(4);
        a_in[0] = 1'b0; wait_n(4);
        c_in[0] = 1'b1;
        expect_pulse(0, 4, "R7");

        // R1: both channels at once, different widths
        cur_req = "R1";
        w_in = {8'd9, 8'd6};
        a_in = 2'b11; wait_n(4);
        a_in = 2'b00;
        wait_n(20);
        check_val(last_len[0], 6, "R1");
        check_val(last_len[1], 9, "R1");

        // Random phase checked by the model
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) begin
                if ($urandom % 6 == 0) a_in[ch] = ~a_in[ch];
                if ($urandom % 6 == 0) b_in[ch] = ~b_in[ch];
                if (c_in[ch]) begin
                    if ($urandom % 40 == 0) c_in[ch] = 1'b0;
                end else if ($urandom % 4 == 0) c_in[ch] = 1'b1;
                if ($urandom % 20 == 0) w_in[ch*WW +: WW] = 8'($urandom % 10);
            end
        end
        wait_n(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule